// File: doc/BRIEF.md
# Split-Plate Beam Position Processor

This block turns a stream of per-bunch amplitudes from the two halves of a split-plate beam pickup into a normalized beam position. Each bunch arrives as a pair of signed samples, one for the right plate and one for the left, together with a strobe. The block forms the plate sum and the plate difference in logic and divides the difference by the sum. It then publishes a signed fixed-point position for that bunch.

The same stream of positions feeds two averagers that run side by side. The first averages consecutive bunches in groups whose size is a power of two, and a batch-start marker restarts a group. The second keeps one accumulator per bunch slot of a revolution. It averages each slot over a programmable, power-of-two number of turns, and a turn-start marker identifies the first bunch of every revolution.

Both group sizes are set through a small write-only configuration port. Each average leaves the block on its own valid flag. The two averagers never stall or alter the per-bunch output.

Top module: `split_plate_bpm`

## Requirements
- R1: For an accepted bunch with right sample r and left sample l (14-bit signed), let s = r + l and d = r − l. When s > 0 and |d| < s, the position `pos` is trunc(|d|·32768 / s), carrying the sign of d (Q1.15 format). When s > 0 and |d| ≥ s, `pos` saturates to +32767 or −32767 according to the sign of d. The value −32768 is never produced.
- R2: When s ≤ 0, `pos` is 0 and `pos_invalid` is 1 in the cycle of that bunch's `pos_valid`. Otherwise `pos_invalid` is 0.
- R3: Every accepted bunch yields exactly one single-cycle `pos_valid` pulse, in bunch order. `batch_valid` and `turn_valid` are raised only in a cycle where `pos_valid` is 1, and they belong to that same bunch.
- R4: A strobe on `in_valid` while a division is still in progress is dropped. It produces no result and causes a one-cycle `overrun` pulse in the following cycle. A strobe accepted while the block is idle leaves `overrun` at 0.
- R5: The batch averager counts positions in groups of 2^kb. A bunch that arrives with `batch_start` = 1 begins a new group, and any partial group is discarded. When a group completes, `batch_valid` pulses and `batch_avg` equals the group's sum arithmetically shifted right by kb.
- R6: A bunch that arrives with `turn_start` = 1 is slot 0, and each later bunch is the next slot. The turn phase is 0 at the first `turn_start` after reset and advances by one at each later `turn_start`, wrapping after 2^kt turns. On the bunch of a slot in the last phase, `turn_valid` pulses and `turn_avg` is that slot's sum over the 2^kt turns, arithmetically shifted right by kt.
- R7: A write with `cfg_wr` = 1 and `cfg_sel` = 0 sets kb, and one with `cfg_sel` = 1 sets kt, both from `cfg_data`. Values above 8 for kb or 10 for kt are clamped to those limits. After reset kb = kt = 0.
- R8: During and right after reset, all outputs are 0.
- R9: A bunch flagged invalid enters both averages with the value 0 and still counts toward the group and turn totals.
- R10: Bunches before the first `turn_start`, and bunches at slot 64 or above, take no part in the turn average and never raise `turn_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Bunch sample strobe |
| right_amp | input | 14 | Right plate amplitude, signed |
| left_amp | input | 14 | Left plate amplitude, signed |
| turn_start | input | 1 | Marks the first bunch of a revolution |
| batch_start | input | 1 | Marks the first bunch of a batch |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the batch shift, 1 selects the turn shift |
| cfg_data | input | 4 | log2 of the group size to write |
| pos_valid | output | 1 | Per-bunch position valid |
| pos | output | 16 | Normalized position, Q1.15 signed |
| pos_invalid | output | 1 | Sum was not positive for this bunch |
| overrun | output | 1 | A strobe was dropped while busy |
| batch_valid | output | 1 | Batch average valid |
| batch_avg | output | 16 | Batch average position |
| turn_valid | output | 1 | Multi-turn average valid |
| turn_avg | output | 16 | Multi-turn average for the current slot |

## Verification
Directed plate pairs cover the main cases of the division. Equal plates check a zero result, and a three-to-one split checks the half-scale quotient in both signs. Opposite-signed plates whose difference exceeds their sum separate saturation from the normal quotient, and zero or negative sums separate the invalid path from the rest. Random plate pairs then run through turns of fixed length, with batch markers placed at turn boundaries or only once. This shows that partial-group restarts, slot indexing and phase wrap are kept apart in the two averagers. Back-to-back strobes expose the overrun rule, and a long run at the clamped limits shows the largest group sizes.

// File: rtl/spb_pkg.sv
package spb_pkg;
  typedef enum logic {CFG_BATCH = 1'b0, CFG_TURN = 1'b1} cfg_sel_e;

  function automatic logic [7:0] clamp_shift(input logic [7:0] v, input logic [7:0] lim);
    return (v > lim) ? lim : v;
  endfunction
endpackage

// File: rtl/spb_divider.sv
module spb_divider #(
  parameter int SAMP_W = 14,
  parameter int FRAC_W = 16,
  parameter int TAG_W  = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic signed [SAMP_W-1:0] right_s,
  input  logic signed [SAMP_W-1:0] left_s,
  input  logic [TAG_W-1:0]         tag_in,
  output logic                     busy,
  output logic                     done,
  output logic                     bad,
  output logic signed [FRAC_W-1:0] quo,
  output logic [TAG_W-1:0]         tag_out
);
  localparam int SUM_W = SAMP_W + 1;
  localparam int ITER  = FRAC_W - 1;
  localparam int CNT_W = $clog2(ITER);

  logic signed [SUM_W-1:0] sum_c, dif_c;
  logic [SUM_W-1:0] mag_c;
  logic             sum_bad;

  assign sum_c   = {right_s[SAMP_W-1], right_s} + {left_s[SAMP_W-1], left_s};
  assign dif_c   = {right_s[SAMP_W-1], right_s} - {left_s[SAMP_W-1], left_s};
  assign mag_c   = dif_c[SUM_W-1] ? -dif_c : dif_c;
  assign sum_bad = sum_c[SUM_W-1] || (sum_c == '0);

  logic [SUM_W-1:0] rem, den;
  logic [ITER-2:0]  qr;
  logic [CNT_W-1:0] cnt;
  logic             neg, sat, bad_r;
  logic [TAG_W-1:0] tag_r;

  // one restoring step: shift remainder, try to subtract the denominator
  logic [SUM_W:0]  shifted;
  logic            ge;
  logic [ITER-1:0] q_next, mag_out;
  assign shifted = {rem, 1'b0};
  assign ge      = shifted >= {1'b0, den};
  assign q_next  = {qr, ge};
  assign mag_out = sat ? '1 : q_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; done <= 1'b0; bad <= 1'b0; quo <= '0; tag_out <= '0;
      rem <= '0; den <= '0; qr <= '0; cnt <= '0;
      neg <= 1'b0; sat <= 1'b0; bad_r <= 1'b0; tag_r <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        cnt   <= '0;
        rem   <= mag_c;
        den   <= sum_c;
        qr    <= '0;
        neg   <= dif_c[SUM_W-1];
        sat   <= mag_c >= $unsigned(sum_c);
        bad_r <= sum_bad;
        tag_r <= tag_in;
      end else if (busy) begin
        rem <= ge ? SUM_W'(shifted - {1'b0, den}) : SUM_W'(shifted);
        qr  <= q_next[ITER-2:0];
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(ITER - 1)) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          bad     <= bad_r;
          tag_out <= tag_r;
          if (bad_r)    quo <= '0;
          else if (neg) quo <= -$signed({1'b0, mag_out});
          else          quo <= $signed({1'b0, mag_out});
        end
      end
    end
  end
endmodule

// File: rtl/spb_batch_avg.sv
module spb_batch_avg #(
  parameter int POS_W  = 16,
  parameter int MAX_SH = 8,
  parameter int SH_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [POS_W-1:0] pos_in,
  input  logic                    first,
  input  logic [SH_W-1:0]         shift,
  output logic                    avg_valid,
  output logic signed [POS_W-1:0] avg
);
  localparam int ACC_W = POS_W + MAX_SH;
  localparam int CNT_W = MAX_SH + 1;

  logic signed [ACC_W-1:0] acc, acc_n;
  logic [CNT_W-1:0]        cnt, cnt_n, target;

  assign acc_n  = first ? ACC_W'(pos_in) : acc + ACC_W'(pos_in);
  assign cnt_n  = first ? CNT_W'(1) : cnt + 1'b1;
  assign target = CNT_W'(1) << shift;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0; cnt <= '0; avg_valid <= 1'b0; avg <= '0;
    end else begin
      avg_valid <= 1'b0;
      if (in_valid) begin
        if (cnt_n == target) begin
          avg_valid <= 1'b1;
          avg       <= POS_W'(acc_n >>> shift);
          acc       <= '0;
          cnt       <= '0;
        end else begin
          acc <= acc_n;
          cnt <= cnt_n;
        end
      end
    end
  end
endmodule

// File: rtl/spb_turn_avg.sv
module spb_turn_avg #(
  parameter int POS_W  = 16,
  parameter int SLOTS  = 64,
  parameter int MAX_SH = 10,
  parameter int SH_W   = 4,
  parameter int IDX_W  = $clog2(SLOTS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [SH_W-1:0]         shift,
  // accept side: tag the bunch entering the divider
  input  logic                    accept,
  input  logic                    turn_start,
  output logic                    t_en,
  output logic [IDX_W-1:0]        t_slot,
  output logic                    t_first,
  output logic                    t_last,
  // result side
  input  logic                    res_valid,
  input  logic signed [POS_W-1:0] res_pos,
  input  logic                    res_en,
  input  logic [IDX_W-1:0]        res_slot,
  input  logic                    res_first,
  input  logic                    res_last,
  output logic                    avg_valid,
  output logic signed [POS_W-1:0] avg
);
  localparam int ACC_W  = POS_W + MAX_SH;
  localparam int SLOT_W = $clog2(SLOTS + 1);
  localparam int PH_W   = MAX_SH + 1;

  logic signed [ACC_W-1:0] mem [SLOTS];
  logic signed [ACC_W-1:0] rd_q, sum_n;
  logic                    started;
  logic [PH_W-1:0]         phase, nxt_phase, ph_used, last_ph;
  logic [SLOT_W-1:0]       slot_cnt, nxt_slot;

  assign last_ph   = (PH_W'(1) << shift) - 1'b1;
  assign nxt_phase = (!started || phase >= last_ph) ? '0 : phase + 1'b1;
  assign nxt_slot  = turn_start ? '0 :
                     (slot_cnt == SLOT_W'(SLOTS)) ? slot_cnt : slot_cnt + 1'b1;
  assign ph_used   = turn_start ? nxt_phase : phase;
  assign t_en      = (turn_start || started) && (nxt_slot < SLOT_W'(SLOTS));
  assign t_slot    = IDX_W'(nxt_slot);
  assign t_first   = (ph_used == '0);
  assign t_last    = (ph_used >= last_ph);

  always_ff @(posedge clk) begin
    if (rst) begin
      started <= 1'b0; phase <= '0; slot_cnt <= '0;
    end else if (accept) begin
      slot_cnt <= nxt_slot;
      if (turn_start) begin
        started <= 1'b1;
        phase   <= nxt_phase;
      end
    end
  end

  // synchronous read at accept, write at result: maps onto block RAM
  always_ff @(posedge clk) begin
    if (accept) rd_q <= mem[t_slot];
    if (res_valid && res_en) mem[res_slot] <= sum_n;
  end

  assign sum_n = (res_first ? '0 : rd_q) + ACC_W'(res_pos);

  always_ff @(posedge clk) begin
    if (rst) begin
      avg_valid <= 1'b0; avg <= '0;
    end else begin
      avg_valid <= 1'b0;
      if (res_valid && res_en && res_last) begin
        avg_valid <= 1'b1;
        avg       <= POS_W'(sum_n >>> shift);
      end
    end
  end
endmodule

// File: rtl/split_plate_bpm.sv
module split_plate_bpm
  import spb_pkg::*;
#(
  parameter int SAMP_W       = 14,
  parameter int FRAC_W       = 16,
  parameter int SLOTS        = 64,
  parameter int BATCH_MAX_SH = 8,
  parameter int TURN_MAX_SH  = 10,
  parameter int CFG_W        = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [SAMP_W-1:0] right_amp,
  input  logic signed [SAMP_W-1:0] left_amp,
  input  logic                     turn_start,
  input  logic                     batch_start,
  input  logic                     cfg_wr,
  input  logic                     cfg_sel,
  input  logic [CFG_W-1:0]         cfg_data,
  output logic                     pos_valid,
  output logic signed [FRAC_W-1:0] pos,
  output logic                     pos_invalid,
  output logic                     overrun,
  output logic                     batch_valid,
  output logic signed [FRAC_W-1:0] batch_avg,
  output logic                     turn_valid,
  output logic signed [FRAC_W-1:0] turn_avg
);
  localparam int IDX_W = $clog2(SLOTS);
  localparam int TAG_W = IDX_W + 4;

  logic [CFG_W-1:0] kb, kt;

  always_ff @(posedge clk) begin
    if (rst) begin
      kb <= '0; kt <= '0;
    end else if (cfg_wr) begin
      if (cfg_sel == CFG_TURN) kt <= CFG_W'(clamp_shift(8'(cfg_data), 8'(TURN_MAX_SH)));
      else                     kb <= CFG_W'(clamp_shift(8'(cfg_data), 8'(BATCH_MAX_SH)));
    end
  end

  logic div_busy, div_done, div_bad, accept;
  logic signed [FRAC_W-1:0] div_q;
  logic [TAG_W-1:0] tag_in, tag_out;
  logic t_en, t_first, t_last;
  logic [IDX_W-1:0] t_slot;

  assign accept = in_valid && !div_busy;
  assign tag_in = {batch_start, t_en, t_slot, t_first, t_last};

  spb_divider #(.SAMP_W(SAMP_W), .FRAC_W(FRAC_W), .TAG_W(TAG_W)) u_div (
    .clk(clk), .rst(rst), .start(accept), .right_s(right_amp), .left_s(left_amp),
    .tag_in(tag_in), .busy(div_busy), .done(div_done), .bad(div_bad),
    .quo(div_q), .tag_out(tag_out)
  );

  logic res_bs, res_en, res_first, res_last;
  logic [IDX_W-1:0] res_slot;
  assign {res_bs, res_en, res_slot, res_first, res_last} = tag_out;

  spb_batch_avg #(.POS_W(FRAC_W), .MAX_SH(BATCH_MAX_SH), .SH_W(CFG_W)) u_batch (
    .clk(clk), .rst(rst), .in_valid(div_done), .pos_in(div_q), .first(res_bs),
    .shift(kb), .avg_valid(batch_valid), .avg(batch_avg)
  );

  spb_turn_avg #(.POS_W(FRAC_W), .SLOTS(SLOTS), .MAX_SH(TURN_MAX_SH), .SH_W(CFG_W),
                 .IDX_W(IDX_W)) u_turn (
    .clk(clk), .rst(rst), .shift(kt), .accept(accept), .turn_start(turn_start),
    .t_en(t_en), .t_slot(t_slot), .t_first(t_first), .t_last(t_last),
    .res_valid(div_done), .res_pos(div_q), .res_en(res_en), .res_slot(res_slot),
    .res_first(res_first), .res_last(res_last),
    .avg_valid(turn_valid), .avg(turn_avg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_valid <= 1'b0; pos <= '0; pos_invalid <= 1'b0; overrun <= 1'b0;
    end else begin
      pos_valid   <= div_done;
      pos_invalid <= div_done && div_bad;
      overrun     <= in_valid && div_busy;
      if (div_done) pos <= div_q;
    end
  end
endmodule

// File: rtl/split_plate_bpm_chk.sv
module split_plate_bpm_chk #(
  parameter int FRAC_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic                     pos_valid,
  input logic signed [FRAC_W-1:0] pos,
  input logic                     pos_invalid,
  input logic                     overrun,
  input logic                     batch_valid,
  input logic                     turn_valid
);
  localparam logic signed [FRAC_W-1:0] MOST_NEG = {1'b1, {(FRAC_W-1){1'b0}}};

  AST_INVALID_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
    pos_invalid |-> (pos_valid && pos == '0)); // R2
  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    pos_valid |-> (pos != MOST_NEG)); // R1
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    pos_valid |=> !pos_valid); // R3
  AST_AVG_WITH_POS: assert property (@(posedge clk) disable iff (rst)
    (batch_valid || turn_valid) |-> pos_valid); // R3
  AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (rst)
    overrun |-> $past(in_valid)); // R4
endmodule

bind split_plate_bpm split_plate_bpm_chk #(.FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .pos_valid(pos_valid), .pos(pos),
  .pos_invalid(pos_invalid), .overrun(overrun), .batch_valid(batch_valid),
  .turn_valid(turn_valid)
);

// File: tb/split_plate_bpm_tb.sv
`timescale 1ns/1ps
module split_plate_bpm_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, turn_start = 1'b0, batch_start = 1'b0;
  logic cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [3:0] cfg_data = '0;
  logic signed [13:0] right_amp = '0, left_amp = '0;
  logic pos_valid, pos_invalid, overrun, batch_valid, turn_valid;
  logic signed [15:0] pos, batch_avg, turn_avg;

  always #2.5 clk = ~clk;

  split_plate_bpm u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .right_amp(right_amp), .left_amp(left_amp),
    .turn_start(turn_start), .batch_start(batch_start), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .pos_valid(pos_valid), .pos(pos), .pos_invalid(pos_invalid),
    .overrun(overrun), .batch_valid(batch_valid), .batch_avg(batch_avg),
    .turn_valid(turn_valid), .turn_avg(turn_avg)
  );

  int checks = 0, errors = 0;
  int kb = 0, kt = 0;
  longint bacc = 0;
  int bcnt = 0;
  bit started = 0;
  int phase = 0, slot = 0;
  longint tacc [64];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint exp_pos(input int r, input int l, output bit inv);
    longint s, d, ad, m;
    s = r + l; d = r - l;
    inv = 0;
    if (s <= 0) begin inv = 1; return 0; end
    ad = (d < 0) ? -d : d;
    m = (ad >= s) ? 32767 : (ad * 32768) / s;
    return (d < 0) ? -m : m;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    kb = 0; kt = 0; bacc = 0; bcnt = 0; started = 0; phase = 0; slot = 0;
  endtask

  task automatic cfg_write(input bit sel, input int val);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_data = 4'(val);
    @(negedge clk);
    cfg_wr = 1'b0;
    if (sel) kt = (val > 10) ? 10 : val;
    else     kb = (val > 8) ? 8 : val;
  endtask

  // turn model at accept time
  task automatic turn_tag(input bit ts, output bit en, output int sl, output bit first, output bit last);
    int n;
    n = 1 << kt;
    if (ts) begin
      phase = !started ? 0 : ((phase >= n - 1) ? 0 : phase + 1);
      started = 1; slot = 0;
    end else if (slot != 64) slot++;
    en = started && slot < 64;
    sl = slot; first = (phase == 0); last = (phase >= n - 1);
  endtask

  task automatic await_result(input int r, input int l, input bit bs, input bit en,
                              input int sl, input bit first, input bit last);
    bit inv, got, exp_bv;
    longint p, exp_b;
    got = 0;
    for (int i = 0; i < 40; i++) begin
      if (pos_valid) begin got = 1; break; end
      @(negedge clk);
    end
    chk(got, "R3", "pos_valid seen", got, 1);
    p = exp_pos(r, l, inv);
    chk(pos == p, "R1", "pos", pos, p);
    chk(pos_invalid == inv, "R2", "pos_invalid", pos_invalid, inv);
    // R5 / R9 batch model
    if (bs) begin bacc = p; bcnt = 1; end else begin bacc += p; bcnt++; end
    exp_bv = (bcnt == (1 << kb));
    exp_b = bacc >>> kb;
    chk(batch_valid == exp_bv, "R5", "batch_valid", batch_valid, exp_bv);
    if (exp_bv) begin
      chk(batch_avg == exp_b, "R5", "batch_avg", batch_avg, exp_b);
      bacc = 0; bcnt = 0;
    end
    // R6 / R10 turn model
    if (en) tacc[sl] = (first ? 0 : tacc[sl]) + p;
    chk(turn_valid == (en && last), "R6", "turn_valid", turn_valid, en && last);
    if (en && last) chk(turn_avg == (tacc[sl] >>> kt), "R6", "turn_avg", turn_avg, tacc[sl] >>> kt);
    @(negedge clk);
    chk(!pos_valid, "R3", "single pulse", pos_valid, 0);
  endtask

  task automatic send(input int r, input int l, input bit ts, input bit bs);
    bit en, first, last;
    int sl;
    turn_tag(ts, en, sl, first, last);
    @(negedge clk);
    in_valid = 1'b1; right_amp = 14'(r); left_amp = 14'(l);
    turn_start = ts; batch_start = bs;
    @(negedge clk);
    in_valid = 1'b0; turn_start = 1'b0; batch_start = 1'b0;
    chk(!overrun, "R4", "overrun when idle", overrun, 0);
    await_result(r, l, bs, en, sl, first, last);
  endtask

  function automatic int rnd_amp();
    if ($urandom_range(0, 7) == 0) return int'($urandom_range(0, 16383)) - 8192;
    return int'($urandom_range(0, 8000));
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R8 reset state
    chk(!pos_valid && !pos_invalid && !overrun && !batch_valid && !turn_valid, "R8",
        "reset flags", {pos_valid, pos_invalid, overrun, batch_valid, turn_valid}, 0);
    chk(pos == 0 && batch_avg == 0 && turn_avg == 0, "R8", "reset data", pos, 0);

    // R1 / R2 directed; R7 reset kb=0 gives batch per bunch
    send(1000, 1000, 0, 0);
    send(3000, 1000, 0, 0);
    send(1000, 3000, 0, 0);
    send(100, -50, 0, 0);
    send(-50, 100, 0, 0);
    send(1, 0, 0, 0);
    send(0, 0, 0, 0);
    send(-100, 50, 0, 0);
    send(8191, -8192, 0, 0);
    send(8191, 8191, 0, 0);
    send(-8192, 1, 0, 0);

    // R4 overrun: second strobe while dividing is dropped
    begin
      bit en, first, last;
      int sl;
      turn_tag(0, en, sl, first, last);
      @(negedge clk);
      in_valid = 1'b1; right_amp = 14'(2000); left_amp = 14'(500);
      @(negedge clk);
      right_amp = 14'(100); left_amp = 14'(900);
      @(negedge clk);
      in_valid = 1'b0;
      chk(overrun, "R4", "overrun pulse", overrun, 1);
      await_result(2000, 500, 0, en, sl, first, last);
      begin
        bit extra = 0;
        for (int i = 0; i < 40; i++) begin
          if (pos_valid) extra = 1;
          @(negedge clk);
        end
        chk(!extra, "R4", "dropped bunch gave no result", extra, 0);
      end
    end

    // R5 / R6 random turns, batch restart at each turn start
    do_reset();
    cfg_write(0, 2);
    cfg_write(1, 1);
    for (int t = 0; t < 4; t++)
      for (int b = 0; b < 6; b++) send(rnd_amp(), rnd_amp(), b == 0, b == 0);

    // R5 / R6 / R9 longer windows, single batch marker
    do_reset();
    cfg_write(0, 3);
    cfg_write(1, 2);
    for (int t = 0; t < 8; t++)
      for (int b = 0; b < 5; b++) send(rnd_amp(), rnd_amp(), b == 0, t == 0 && b == 0);

    // R10 before first turn start and beyond last slot
    do_reset();
    for (int b = 0; b < 3; b++) send(rnd_amp(), rnd_amp(), 0, 0);
    for (int b = 0; b < 70; b++) send(rnd_amp(), rnd_amp(), b == 0, 0);

    // R7 clamp: 15 -> 8 for batch, 12 -> 10 for turn
    do_reset();
    cfg_write(0, 15);
    cfg_write(1, 12);
    for (int b = 0; b < 1024; b++) send(int'($urandom_range(0, 4000)), int'($urandom_range(0, 4000)), 1, 0);

    finish_run();
  end
endmodule